// File: doc/BRIEF.md
# Split-Word Register Access Bridge

This block lets a host with a 32-bit register port reach a register space whose registers are 64 bits wide. The host stages a 64-bit value as two 32-bit halves and then writes a command word. The command's most significant bit picks the direction, and the remaining 31 bits name the internal register. The bridge runs one access on an internal request/acknowledge bus and reports the outcome in a status word.

For a write, the internal value is the upper half joined to the lower half. For a read, the fetched 64-bit value is split back into the two data registers, where the host picks it up with two plain reads. An error flag in the status word stays set until the host writes to a clear register. The flag records a bus error, an acknowledge that never arrives within a fixed window, or a command issued while an access is still running.

Top module: `rab_bridge`

## Requirements
- R1: After reset, both data registers, the command register and the status word read 0, and `ib_req` is low.
- R2: A host write to offset 0x00 stores the upper data half, and a write to 0x04 stores the lower half. Reading either one returns the stored value, and repeated reads change nothing.
- R3: A write to the command offset 0x08 while idle raises `ib_req` on the next cycle. At that point `ib_we` equals command bit 31, `ib_addr` equals command bits 30:0, and `ib_wdata` equals {upper, lower} as held before the command. All of these stay steady until the access ends.
- R4: When a read access is acknowledged without error, the upper data register takes `ib_rdata[63:32]` and the lower one takes `ib_rdata[31:0]`, visible the cycle after the acknowledge. A write access leaves both data registers unchanged.
- R5: Status bit 0 (busy) reads 1 from the cycle after a command is accepted until the cycle after its access ends. `ib_req` drops in that same cycle.
- R6: A command written while busy is dropped: the running access continues unchanged, and status bit 31 (error) is set.
- R7: If `ib_err` is high in a cycle while `ib_req` is high, the access ends, status bit 31 is set and the data registers are not loaded. `ib_err` takes precedence over `ib_ack`.
- R8: If neither `ib_ack` nor `ib_err` arrives, `ib_req` stays high for exactly TIMEOUT cycles, then drops with status bit 31 set and the data registers unchanged.
- R9: A write of any value to offset 0x18 clears the error flag and both data registers. It takes precedence over a load or an error in the same cycle.
- R10: Writes to the status offset 0x1C, the interrupt offset 0x20 and any unmapped offset have no effect. Reads of 0x20 and of unmapped offsets return 0. A read of 0x08 returns the last accepted command.
- R11: The error flag is sticky: later successful accesses do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Read data for `h_addr`, combinational |
| ib_req | output | 1 | Internal access request, held until acknowledged, errored or timed out |
| ib_we | output | 1 | Internal access direction, 1 = write |
| ib_addr | output | 31 | Internal register address |
| ib_wdata | output | 64 | Internal write value |
| ib_ack | input | 1 | Internal access acknowledge |
| ib_err | input | 1 | Internal access error |
| ib_rdata | input | 64 | Internal read value, valid with `ib_ack` |

## Verification
The bench builds the bridge with TIMEOUT set to 6. This keeps the no-acknowledge case short, so the exact length of the request window can be counted and the later recovery checked in the same run. Its responder acknowledges after a chosen number of request cycles, or answers with an error. This lets commands be issued while an access is pending, lets errors race acknowledges, and lets clears land while the flag is set. A behavioural model predicts the request signals and every addressed read on each cycle.

// File: rtl/rab_pkg.sv
package rab_pkg;
    localparam int OFS_W = 8;

    localparam logic [OFS_W-1:0] OFS_UPPER = 8'h00;
    localparam logic [OFS_W-1:0] OFS_LOWER = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CMD   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CLEAR = 8'h18;
    localparam logic [OFS_W-1:0] OFS_STAT  = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_IRQ   = 8'h20;

    typedef struct packed {
        logic upper;
        logic lower;
        logic cmd;
        logic clear;
    } wr_strobe_t;
endpackage

// File: rtl/rab_host_decode.sv
module rab_host_decode
    import rab_pkg::*;
#(
    parameter int HDATA_W = 32
) (
    input  logic               h_we,
    input  logic [OFS_W-1:0]   h_addr,
    input  logic [HDATA_W-1:0] upper_q,
    input  logic [HDATA_W-1:0] lower_q,
    input  logic [HDATA_W-1:0] cmd_q,
    input  logic [HDATA_W-1:0] stat_w,
    output wr_strobe_t         stb,
    output logic [HDATA_W-1:0] h_rdata
);
    always_comb begin
        stb       = '0;
        stb.upper = h_we && (h_addr == OFS_UPPER);
        stb.lower = h_we && (h_addr == OFS_LOWER);
        stb.cmd   = h_we && (h_addr == OFS_CMD);
        stb.clear = h_we && (h_addr == OFS_CLEAR);
    end

    always_comb begin
        unique case (h_addr)
            OFS_UPPER: h_rdata = upper_q;
            OFS_LOWER: h_rdata = lower_q;
            OFS_CMD:   h_rdata = cmd_q;
            OFS_STAT:  h_rdata = stat_w;
            OFS_IRQ:   h_rdata = '0;
            default:   h_rdata = '0;
        endcase
    end

    always_comb begin
        assert_onehot_strobe_R10: assert ($onehot0(stb));
    end
endmodule

// File: rtl/rab_access_fsm.sv
module rab_access_fsm #(
    parameter int IADDR_W = 31,
    parameter int IDATA_W = 64,
    parameter int TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_we,
    input  logic [IADDR_W-1:0] start_addr,
    input  logic [IDATA_W-1:0] start_wdata,
    input  logic               ib_ack,
    input  logic               ib_err,
    output logic               ib_req,
    output logic               ib_we,
    output logic [IADDR_W-1:0] ib_addr,
    output logic [IDATA_W-1:0] ib_wdata,
    output logic               busy,
    output logic               load_rd,
    output logic               fail
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic               req;
        logic               we;
        logic [IADDR_W-1:0] addr;
        logic [IDATA_W-1:0] wdata;
        logic [CNT_W-1:0]   cnt;
    } acc_t;

    acc_t acc_d, acc_q;
    logic expired;

    always_comb begin
        acc_d   = acc_q;
        expired = acc_q.req && !ib_ack && !ib_err && (acc_q.cnt == CNT_LAST);
        load_rd = acc_q.req && ib_ack && !ib_err && !acc_q.we;
        fail    = (acc_q.req && ib_err) || expired;
        if (acc_q.req) begin
            if (ib_ack || ib_err || expired) begin
                acc_d.req = 1'b0;
                acc_d.cnt = '0;
            end else begin
                acc_d.cnt = acc_q.cnt + 1'b1;
            end
        end else if (start) begin
            acc_d.req   = 1'b1;
            acc_d.we    = start_we;
            acc_d.addr  = start_addr;
            acc_d.wdata = start_wdata;
            acc_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign ib_req   = acc_q.req;
    assign ib_we    = acc_q.we;
    assign ib_addr  = acc_q.addr;
    assign ib_wdata = acc_q.wdata;
    assign busy     = acc_q.req;

    assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack && !ib_err && !expired) |=>
            (ib_req && $stable(ib_we) && $stable(ib_addr) && $stable(ib_wdata)));

    assert_drop_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && (ib_ack || ib_err)) |=> !ib_req);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q.cnt <= CNT_LAST);

    assert_err_blocks_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ib_err |-> !load_rd);
endmodule

// File: rtl/rab_bridge.sv
module rab_bridge
    import rab_pkg::*;
#(
    parameter int HDATA_W = 32,
    parameter int TIMEOUT = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   h_we,
    input  logic [7:0]             h_addr,
    input  logic [HDATA_W-1:0]     h_wdata,
    output logic [HDATA_W-1:0]     h_rdata,
    output logic                   ib_req,
    output logic                   ib_we,
    output logic [HDATA_W-2:0]     ib_addr,
    output logic [2*HDATA_W-1:0]   ib_wdata,
    input  logic                   ib_ack,
    input  logic                   ib_err,
    input  logic [2*HDATA_W-1:0]   ib_rdata
);
    localparam int IDATA_W = 2 * HDATA_W;
    localparam int IADDR_W = HDATA_W - 1;

    typedef struct packed {
        logic [HDATA_W-1:0] upper;
        logic [HDATA_W-1:0] lower;
        logic [HDATA_W-1:0] cmd;
        logic               err;
    } hreg_t;

    hreg_t      r_d, r_q;
    wr_strobe_t stb;
    logic       busy, load_rd, fail, start;
    logic [HDATA_W-1:0] stat_w;

    assign stat_w = {r_q.err, {(HDATA_W-2){1'b0}}, busy};
    assign start  = stb.cmd && !busy;

    rab_host_decode #(.HDATA_W(HDATA_W)) u_dec (
        .h_we    (h_we),
        .h_addr  (h_addr),
        .upper_q (r_q.upper),
        .lower_q (r_q.lower),
        .cmd_q   (r_q.cmd),
        .stat_w  (stat_w),
        .stb     (stb),
        .h_rdata (h_rdata)
    );

    rab_access_fsm #(
        .IADDR_W (IADDR_W),
        .IDATA_W (IDATA_W),
        .TIMEOUT (TIMEOUT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_we    (h_wdata[HDATA_W-1]),
        .start_addr  (h_wdata[HDATA_W-2:0]),
        .start_wdata ({r_q.upper, r_q.lower}),
        .ib_ack      (ib_ack),
        .ib_err      (ib_err),
        .ib_req      (ib_req),
        .ib_we       (ib_we),
        .ib_addr     (ib_addr),
        .ib_wdata    (ib_wdata),
        .busy        (busy),
        .load_rd     (load_rd),
        .fail        (fail)
    );

    always_comb begin
        r_d = r_q;
        if (load_rd) begin
            r_d.upper = ib_rdata[IDATA_W-1:HDATA_W];
            r_d.lower = ib_rdata[HDATA_W-1:0];
        end
        if (fail) r_d.err = 1'b1;
        if (stb.upper) r_d.upper = h_wdata;
        if (stb.lower) r_d.lower = h_wdata;
        if (stb.cmd) begin
            if (busy) r_d.err = 1'b1;
            else      r_d.cmd = h_wdata;
        end
        if (stb.clear) begin
            r_d.upper = '0;
            r_d.lower = '0;
            r_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_cmd_busy_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.cmd && ib_req && !stb.clear) |=> r_q.err);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err && !stb.clear) |=> r_q.err);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stb.clear |=> (!r_q.err && r_q.upper == '0 && r_q.lower == '0));

    assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.cmd && !ib_req) |=> (ib_req && ib_we == $past(h_wdata[HDATA_W-1])));
endmodule

// File: tb/sim_rab_bridge.sv
module sim_rab_bridge;
    localparam int TMO = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_we = 1'b0;
    logic [7:0]  h_addr = 8'h1C;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        ib_req, ib_we;
    logic [30:0] ib_addr;
    logic [63:0] ib_wdata;
    logic        ib_ack = 1'b0, ib_err = 1'b0;
    logic [63:0] ib_rdata = '0;

    always #10 clk = ~clk;

    rab_bridge #(.HDATA_W(32), .TIMEOUT(TMO)) u0 (.*);

    int n_chk = 0, n_fail = 0, cyc = 0, age = 0, lat = 1;
    bit rsp_err = 1'b0;

    // behavioural reference state
    logic [31:0] m_hi, m_lo, m_cmd;
    logic        m_err, m_req, m_we;
    logic [30:0] m_addr;
    logic [63:0] m_wd;
    int          m_age;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_hi;
            8'h04: return m_lo;
            8'h08: return m_cmd;
            8'h1C: return {m_err, 30'd0, m_req};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_cmd = 0; m_err = 0; m_req = 0;
            m_we = 0; m_addr = 0; m_wd = 0; m_age = 0;
        end else begin
            automatic bit was_busy = m_req;
            automatic logic [63:0] staged = {m_hi, m_lo};
            if (m_req) begin
                if (ib_err) begin m_req = 0; m_err = 1; end
                else if (ib_ack) begin
                    m_req = 0;
                    if (!m_we) begin m_hi = ib_rdata[63:32]; m_lo = ib_rdata[31:0]; end
                end else if (m_age == TMO - 1) begin m_req = 0; m_err = 1; end
                else m_age++;
            end
            if (h_we) begin
                case (h_addr)
                    8'h00: m_hi = h_wdata;
                    8'h04: m_lo = h_wdata;
                    8'h08: if (was_busy) m_err = 1;
                           else begin
                               m_req = 1; m_age = 0; m_we = h_wdata[31];
                               m_addr = h_wdata[30:0]; m_wd = staged; m_cmd = h_wdata;
                           end
                    8'h18: begin m_hi = 0; m_lo = 0; m_err = 0; end
                    default: ;
                endcase
            end
        end
    end

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (rst_n) begin
            chk("R3 ib_req", ib_req, m_req);
            if (m_req) begin
                chk("R3 ib_we", ib_we, m_we);
                chk("R3 ib_addr", ib_addr, m_addr);
                chk("R3 ib_wdata", ib_wdata, m_wd);
            end
            chk((h_addr inside {8'h00, 8'h04}) ? "R2 model read" :
                (h_addr == 8'h1C) ? "R5 model status" : "R10 model read",
                h_rdata, m_read(h_addr));
        end
        if (ib_req) age++; else age = 0;
        ib_ack  = ib_req && (age == lat) && !rsp_err;
        ib_err  = ib_req && (age == lat) && rsp_err;
        h_we    = we;
        h_addr  = a;
        h_wdata = d;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'd0);
        chk(tag, h_rdata, exp);
    endtask

    task automatic wait_idle();
        step(1'b0, 8'h1C, 32'd0);
        for (int i = 0; i < 50 && ib_req; i++) step(1'b0, 8'h1C, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 32'd0, "R1 upper");
        rd(8'h04, 32'd0, "R1 lower");
        rd(8'h1C, 32'd0, "R1 status");
        rd(8'h08, 32'd0, "R1 cmd");
        chk("R1 ib_req", ib_req, 1'b0);

        // R2 staging and side-effect-free reads
        step(1'b1, 8'h00, 32'hA5A5_0001);
        step(1'b1, 8'h04, 32'h5A5A_0002);
        rd(8'h00, 32'hA5A5_0001, "R2 upper");
        rd(8'h00, 32'hA5A5_0001, "R2 upper reread");
        rd(8'h04, 32'h5A5A_0002, "R2 lower");

        // R3 write command
        lat = 2;
        step(1'b1, 8'h08, 32'h8007_0023);
        rd(8'h1C, 32'h0000_0001, "R5 busy set");
        chk("R3 we", ib_we, 1'b1);
        chk("R3 addr", ib_addr, 31'h0007_0023);
        chk("R3 wdata", ib_wdata, 64'hA5A5_0001_5A5A_0002);
        wait_idle();
        rd(8'h1C, 32'd0, "R5 busy cleared");
        rd(8'h00, 32'hA5A5_0001, "R4 write keeps upper");

        // R4 read command
        lat = 3;
        ib_rdata = 64'h1122_3344_5566_7788;
        step(1'b1, 8'h08, 32'h0007_0026);
        step(1'b0, 8'h1C, 32'd0);
        chk("R3 read dir", ib_we, 1'b0);
        wait_idle();
        rd(8'h00, 32'h1122_3344, "R4 upper");
        rd(8'h04, 32'h5566_7788, "R4 lower");

        // R6 command while busy
        lat = 5;
        ib_rdata = 64'h0BAD_F00D_600D_CAFE;
        step(1'b1, 8'h08, 32'h0007_0029);
        step(1'b1, 8'h08, 32'h8000_0001);
        step(1'b0, 8'h1C, 32'd0);
        chk("R6 dir kept", ib_we, 1'b0);
        chk("R6 addr kept", ib_addr, 31'h0007_0029);
        wait_idle();
        rd(8'h1C, 32'h8000_0000, "R6 error");
        rd(8'h08, 32'h0007_0029, "R10 cmd readback");
        rd(8'h00, 32'h0BAD_F00D, "R6 first access completed");

        // R11 sticky
        lat = 1;
        step(1'b1, 8'h08, 32'h8007_0021);
        wait_idle();
        rd(8'h1C, 32'h8000_0000, "R11 sticky");

        // R9 clear
        step(1'b1, 8'h18, 32'h0);
        rd(8'h1C, 32'd0, "R9 status");
        rd(8'h00, 32'd0, "R9 upper");
        rd(8'h04, 32'd0, "R9 lower");

        // R7 bus error
        step(1'b1, 8'h00, 32'hCAFE_0001);
        step(1'b1, 8'h04, 32'hBEEF_0002);
        rsp_err = 1'b1; lat = 2;
        step(1'b1, 8'h08, 32'h0007_0028);
        wait_idle();
        rsp_err = 1'b0;
        rd(8'h1C, 32'h8000_0000, "R7 error");
        rd(8'h00, 32'hCAFE_0001, "R7 no load");

        // R8 timeout
        step(1'b1, 8'h18, 32'h0);
        step(1'b1, 8'h00, 32'h1234_5678);
        lat = 1000;
        step(1'b1, 8'h08, 32'h0007_002A);
        begin
            automatic int n = 0;
            step(1'b0, 8'h1C, 32'd0);
            while (ib_req && n < 100) begin n++; step(1'b0, 8'h1C, 32'd0); end
            chk("R8 window", n, TMO);
        end
        rd(8'h1C, 32'h8000_0000, "R8 error");
        rd(8'h00, 32'h1234_5678, "R8 no load");
        lat = 1;

        // R10 ignored writes
        step(1'b1, 8'h18, 32'h0);
        step(1'b1, 8'h1C, 32'hFFFF_FFFF);
        step(1'b1, 8'h20, 32'hFFFF_FFFF);
        step(1'b1, 8'h10, 32'hFFFF_FFFF);
        rd(8'h1C, 32'd0, "R10 status write ignored");
        rd(8'h20, 32'd0, "R10 irq reads zero");
        rd(8'h10, 32'd0, "R10 unmapped reads zero");
        rd(8'h00, 32'd0, "R10 upper untouched");
        chk("R10 no request", ib_req, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule